// File: doc/BRIEF.md
# Single-to-Half Float Converter

This block turns a 32-bit single-precision bit pattern into a 16-bit half-precision bit pattern. Rounding is to nearest, with ties going to the even result. The rounding is the same in the normal range and in the subnormal range. Each accepted word produces exactly one result word, one clock later.

A per-word mode bit picks one of two output policies:

- **IEEE policy.** Out-of-range values become infinity, and NaNs become one canonical quiet NaN.
- **Extended-range policy.** The output format has no infinity and no NaN. It uses the all-ones exponent as an ordinary binade, so any value too large to represent is clamped to the largest encodable magnitude.

The block is meant for datapaths that store activations or weights in 16-bit form. The mode is carried with each word, so mixed streams need no reconfiguration.

Top module: `fcvt_s2h`

## Requirements
- R1: When `in_valid` is high on a rising edge, `out_valid` is high after that edge and `out_data` holds the converted word. When `in_valid` is low, `out_valid` is low after that edge and `out_data` keeps its previous value. After reset both outputs are zero.
- R2: Output bit 15 always equals input bit 31, in both modes and for every class of input.
- R3: In IEEE mode (`in_alt`=0), an input with exponent field 255 and a nonzero fraction gives `{sign, 15'h7E00}`.
- R4: In IEEE mode, an input with exponent 255 and a zero fraction gives `{sign, 15'h7C00}`. A finite input whose rounded magnitude reaches 65520 or more also gives `{sign, 15'h7C00}`. No finite input produces exponent field 31 with a nonzero fraction.
- R5: For normal-range results, the output exponent equals the input exponent minus 112. The 23-bit fraction is rounded to 10 bits, to nearest with ties to even; for example 0x3F801000 gives 0x3C00 and 0x3F803000 gives 0x3C02.
- R6: Inputs below 2^-14 are rounded onto the 2^-24 grid and encoded with exponent field 0. 2^-24 gives 0x0001 and 2^-25 (a tie) gives 0x0000. Anything just above 2^-25 gives 0x0001, and 1.5·2^-24 gives 0x0002.
- R7: A rounding carry out of the fraction moves into the exponent field. For example 0x387FE000 (the largest subnormal plus half a step) gives 0x0400, and 0x3FFFF000 gives 0x4000.
- R8: In extended-range mode (`in_alt`=1), any input whose magnitude bits exceed 0x47FFE000 gives `{sign, 15'h7FFF}`. This includes infinities and NaNs.
- R9: In extended-range mode, exponent field 31 is a normal binade. 0x47800000 gives 0x7C00 and 0x477FF000 rounds up to 0x7C00.
- R10: Zero inputs and single-precision subnormal inputs give a signed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | Single-precision bit pattern |
| in_alt | input | 1 | 1 selects the extended-range policy, 0 selects IEEE |
| out_valid | output | 1 | Result word present |
| out_data | output | 16 | Half-precision bit pattern |

## Verification
The checker watches several properties on every cycle:
- the one-cycle valid latency and the output hold while idle;
- the sign passthrough;
- the canonical NaN and the infinity mapping in IEEE mode;
- the absence of non-canonical all-ones-exponent codes in IEEE mode;
- clamping in extended-range mode;
- flushing of tiny inputs to zero;
- the even least significant bit after any exact tie.

The exact rounded values cannot be stated as cheap per-cycle properties:
- the gradual-underflow grid;
- the carry from subnormal into normal;
- the boundary at 65520.

These are shown only by the bench's directed corner scenarios and its independent loop-based rounding model, which is compared on every clock.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int SRC_EXP_W = 8;
  localparam int SRC_MAN_W = 23;
  localparam int DST_EXP_W = 5;
  localparam int DST_MAN_W = 10;

  localparam int SRC_W     = 1 + SRC_EXP_W + SRC_MAN_W;
  localparam int DST_W     = 1 + DST_EXP_W + DST_MAN_W;
  localparam int SRC_MAG_W = SRC_W - 1;
  localparam int DST_MAG_W = DST_W - 1;
  localparam int SRC_BIAS  = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
  localparam int REBIAS    = SRC_BIAS - DST_BIAS;
  localparam int DROP      = SRC_MAN_W - DST_MAN_W;
  localparam int DST_EXP_MAX = (1 << DST_EXP_W) - 1;
  localparam int SIG_W     = SRC_MAN_W + 1;
  // shifting by this much pushes every significand bit below the guard position
  localparam int SHIFT_CAP = SIG_W + 1;
  localparam int EXT_W     = SIG_W + SHIFT_CAP;
  localparam int SH_W      = $clog2(SHIFT_CAP + 1);

  typedef logic [SRC_MAG_W-1:0] src_mag_t;
  typedef logic [DST_MAG_W-1:0] dst_mag_t;

  // largest magnitude of the extended-range format, expressed in the source format
  function automatic src_mag_t f_alt_max_src();
    return {SRC_EXP_W'(DST_EXP_MAX + REBIAS), {DST_MAN_W{1'b1}}, {DROP{1'b0}}};
  endfunction

  function automatic dst_mag_t f_qnan();
    return {{DST_EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};
  endfunction

  function automatic dst_mag_t f_inf();
    return {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
  endfunction

  // nearest-even increment decision
  function automatic logic f_rne(input logic lsb, input logic guard, input logic sticky);
    return guard & (sticky | lsb);
  endfunction
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [SRC_W-1:0]     src,
  input  logic                 alt,
  output logic                 sign,
  output logic                 is_nan,
  output logic                 is_inf,
  output logic [SRC_EXP_W-1:0] exp_f,
  output logic [SRC_MAN_W-1:0] man_f
);
  src_mag_t raw_mag;
  src_mag_t eff_mag;
  logic     clamp_hit;

  always_comb begin
    raw_mag   = src[SRC_MAG_W-1:0];
    sign      = src[SRC_W-1];
    is_nan    = (raw_mag[SRC_MAG_W-1 -: SRC_EXP_W] == '1) && (raw_mag[SRC_MAN_W-1:0] != '0);
    is_inf    = (raw_mag[SRC_MAG_W-1 -: SRC_EXP_W] == '1) && (raw_mag[SRC_MAN_W-1:0] == '0);
    clamp_hit = alt && (raw_mag > f_alt_max_src());
    eff_mag   = clamp_hit ? f_alt_max_src() : raw_mag;
    exp_f     = eff_mag[SRC_MAG_W-1 -: SRC_EXP_W];
    man_f     = eff_mag[SRC_MAN_W-1:0];
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic [SRC_EXP_W-1:0] exp_f,
  input  logic [SRC_MAN_W-1:0] man_f,
  output logic [DST_MAG_W-1:0] mag,
  output logic                 pre_ovf,
  output logic                 rnd_up,
  output logic                 rnd_tie
);
  logic [SIG_W-1:0]     sig;
  logic [EXT_W-1:0]     ext;
  logic [SIG_W-1:0]     kept;
  logic [SH_W-1:0]      shamt;
  logic [31:0]          he_v;
  logic [DST_MAG_W-1:0] base;
  logic                 is_norm;
  logic                 guard;
  logic                 sticky;
  int                   sh_i;

  always_comb begin
    is_norm = int'(exp_f) > REBIAS;
    sig     = {exp_f != '0, man_f};
    if (is_norm) sh_i = DROP;
    else         sh_i = REBIAS + DROP + 1 - int'(exp_f);
    if (sh_i > SHIFT_CAP) sh_i = SHIFT_CAP;
    shamt   = SH_W'(sh_i);
    ext     = {sig, {SHIFT_CAP{1'b0}}} >> shamt;
    kept    = ext[EXT_W-1:SHIFT_CAP];
    guard   = ext[SHIFT_CAP-1];
    sticky  = |ext[SHIFT_CAP-2:0];
    he_v    = 32'(int'(exp_f) - REBIAS);
    base    = is_norm ? {he_v[DST_EXP_W-1:0], kept[DST_MAN_W-1:0]}
                      : {{DST_EXP_W{1'b0}}, kept[DST_MAN_W-1:0]};
    rnd_up  = f_rne(kept[0], guard, sticky);
    rnd_tie = guard & ~sticky;
    mag     = base + {{(DST_MAG_W-1){1'b0}}, rnd_up};
    pre_ovf = int'(exp_f) >= REBIAS + DST_EXP_MAX;
  end
endmodule

// File: rtl/fcvt_select.sv
module fcvt_select
  import fcvt_pkg::*;
(
  input  logic                 alt,
  input  logic                 sign,
  input  logic                 is_nan,
  input  logic                 is_inf,
  input  logic                 pre_ovf,
  input  logic [DST_MAG_W-1:0] mag,
  output logic [DST_W-1:0]     res,
  output logic                 use_mag
);
  logic top_binade;

  always_comb begin
    top_binade = mag[DST_MAG_W-1 -: DST_EXP_W] == '1;
    use_mag    = 1'b1;
    res        = {sign, mag};
    if (!alt) begin
      if (is_nan) begin
        res     = {sign, f_qnan()};
        use_mag = 1'b0;
      end else if (is_inf || pre_ovf || top_binade) begin
        res     = {sign, f_inf()};
        use_mag = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcvt_s2h.sv
module fcvt_s2h
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] in_data,
  input  logic             in_alt,
  output logic             out_valid,
  output logic [DST_W-1:0] out_data
);
  logic                 w_sign;
  logic                 w_nan;
  logic                 w_inf;
  logic [SRC_EXP_W-1:0] w_exp;
  logic [SRC_MAN_W-1:0] w_man;
  logic [DST_MAG_W-1:0] w_mag;
  logic                 w_pre_ovf;
  logic                 w_rnd_up;
  logic                 w_tie;
  logic                 w_use_mag;
  logic [DST_W-1:0]     w_res;

  fcvt_unpack u_unpack (
    .src    (in_data),
    .alt    (in_alt),
    .sign   (w_sign),
    .is_nan (w_nan),
    .is_inf (w_inf),
    .exp_f  (w_exp),
    .man_f  (w_man)
  );

  fcvt_round u_round (
    .exp_f   (w_exp),
    .man_f   (w_man),
    .mag     (w_mag),
    .pre_ovf (w_pre_ovf),
    .rnd_up  (w_rnd_up),
    .rnd_tie (w_tie)
  );

  fcvt_select u_select (
    .alt     (in_alt),
    .sign    (w_sign),
    .is_nan  (w_nan),
    .is_inf  (w_inf),
    .pre_ovf (w_pre_ovf),
    .mag     (w_mag),
    .res     (w_res),
    .use_mag (w_use_mag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= w_res;
    end
  end

  // the increment flag only feeds the magnitude; referenced here so it stays a named probe
  logic w_rnd_probe;
  assign w_rnd_probe = w_rnd_up;
endmodule

// File: rtl/fcvt_s2h_chk.sv
module fcvt_s2h_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        in_alt,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic        w_tie,
  input logic        w_use_mag
);
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_data));
  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[15] == $past(in_data[31]));
  p_nan_canon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_alt && in_data[30:23] == 8'hFF && in_data[22:0] != 23'h0
    |=> out_data[14:0] == 15'h7E00);
  p_inf_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_alt && in_data[30:0] == 31'h7F800000 |=> out_data[14:0] == 15'h7C00);
  p_no_junk_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_alt && in_data[30:23] != 8'hFF
    |=> out_data[14:10] != 5'h1F || out_data[9:0] == 10'h0);
  p_tie_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && w_tie && w_use_mag |=> out_data[0] == 1'b0);
  p_alt_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_alt && in_data[30:0] > 31'h47FFE000 |=> out_data[14:0] == 15'h7FFF);
  p_tiny_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_data[30:23] == 8'h00 |=> out_data[14:0] == 15'h0);
endmodule

bind fcvt_s2h fcvt_s2h_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_alt    (in_alt),
  .out_valid (out_valid),
  .out_data  (out_data),
  .w_tie     (w_tie),
  .w_use_mag (w_use_mag)
);

// File: tb/fcvt_s2h_bench.sv
`timescale 1ns/1ps
module fcvt_s2h_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'h0;
  logic        in_alt = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  int          checks = 0;
  int          errors = 0;
  logic        m_valid;
  logic [15:0] m_data;

  always #4 clk = ~clk;

  fcvt_s2h u_fcvt_s2h (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_alt(in_alt), .out_valid(out_valid), .out_data(out_data)
  );

  // behavioural reference: bit-serial right shift with guard/sticky tracking
  function automatic logic [15:0] ref_cvt(input logic [31:0] f, input logic alt);
    logic   s;
    longint e, sig, ee, top, q, sh, n, bits, mag;
    logic   g, st;
    s   = f[31];
    mag = longint'(f[30:0]);
    if (!alt && f[30:23] == 8'hFF)
      return (f[22:0] != 0) ? {s, 15'h7E00} : {s, 15'h7C00};
    if (alt && mag > 64'h47FFE000) mag = 64'h47FFE000;
    e   = (mag >> 23) & 255;
    sig = (e == 0) ? (mag & 64'h7FFFFF) : ((mag & 64'h7FFFFF) | (64'd1 << 23));
    ee  = (e == 0) ? 1 : e;
    top = ee - 127;
    q   = ((top < -14) ? -14 : top) - 10;
    sh  = q - (ee - 150);
    n = sig; g = 1'b0; st = 1'b0;
    for (longint i = 0; i < sh; i++) begin
      st = st | g;
      g  = n[0];
      n  = n >> 1;
    end
    if (g && (st || n[0])) n = n + 1;
    bits = ((q + 25) << 10) + n - 1024;
    if (!alt && bits >= 64'h7C00) bits = 64'h7C00;
    return {s, bits[14:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // cycle model of the one-register pipeline
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= 16'h0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) m_data <= ref_cvt(in_data, in_alt);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 valid vs model", {15'h0, out_valid}, {15'h0, m_valid});
      chk("R5 data vs model", out_data, m_data);
    end
  end

  task automatic apply(input logic [31:0] d, input logic alt, input logic [15:0] expv, input string tag);
    in_data  = d;
    in_alt   = alt;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {15'h0, out_valid}, 16'h1);
    chk(tag, out_data, expv);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset valid", {15'h0, out_valid}, 16'h0);
    chk("R1 reset data", out_data, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(32'h3F800000, 1'b0, 16'h3C00, "R5 one");
    apply(32'hC0000000, 1'b0, 16'hC000, "R2 minus two");
    apply(32'h3F801000, 1'b0, 16'h3C00, "R5 tie even down");
    apply(32'h3F803000, 1'b0, 16'h3C02, "R5 tie odd up");
    apply(32'h477FE000, 1'b0, 16'h7BFF, "R4 max normal");
    apply(32'h477FEFFF, 1'b0, 16'h7BFF, "R4 below overflow");
    apply(32'h477FF000, 1'b0, 16'h7C00, "R4 round to inf");
    apply(32'h4F000000, 1'b0, 16'h7C00, "R4 large finite");
    apply(32'h7F800000, 1'b0, 16'h7C00, "R4 plus inf");
    apply(32'hFF800000, 1'b0, 16'hFC00, "R4 minus inf");
    apply(32'h7FC00001, 1'b0, 16'h7E00, "R3 nan");
    apply(32'hFF800001, 1'b0, 16'hFE00, "R3 signed nan");
    apply(32'h33800000, 1'b0, 16'h0001, "R6 smallest sub");
    apply(32'h33000000, 1'b0, 16'h0000, "R6 half tie");
    apply(32'h33000001, 1'b0, 16'h0001, "R6 above half");
    apply(32'h33C00000, 1'b0, 16'h0002, "R6 tie odd sub");
    apply(32'hB3800000, 1'b1, 16'h8001, "R6 alt neg sub");
    apply(32'h387FE000, 1'b0, 16'h0400, "R7 sub to normal");
    apply(32'h3FFFF000, 1'b0, 16'h4000, "R7 exponent step");
    apply(32'h7F800000, 1'b1, 16'h7FFF, "R8 alt inf");
    apply(32'hFFC00000, 1'b1, 16'hFFFF, "R8 alt nan");
    apply(32'h4F000000, 1'b1, 16'h7FFF, "R8 alt big");
    apply(32'h47800000, 1'b1, 16'h7C00, "R9 alt 65536");
    apply(32'h477FF000, 1'b1, 16'h7C00, "R9 alt round up");
    apply(32'h47FFE000, 1'b1, 16'h7FFF, "R9 alt max");
    apply(32'h80000000, 1'b0, 16'h8000, "R10 neg zero");
    apply(32'h00000001, 1'b0, 16'h0000, "R10 src subnormal");

    // R1: idle cycle with changed data must not disturb the output
    in_data = 32'h3F800000;
    @(negedge clk);
    chk("R1 idle valid", {15'h0, out_valid}, 16'h0);
    chk("R1 idle hold", out_data, 16'h0000);

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] ex;
      ex = ($urandom % 2 == 0) ? 8'($urandom_range(98, 146)) : 8'($urandom);
      in_data  = {1'($urandom), ex, 23'($urandom)};
      if ($urandom % 16 == 0) in_data[12:0] = 13'h1000;
      in_alt   = 1'($urandom);
      in_valid = ($urandom % 4) != 0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule